// File: doc/BRIEF.md
# Multistage Barrel Shifter

This block shifts a 32-bit word left or right by any distance from 0 to 31 in a single pass. The distance is split into its binary weights, and a cascade of multiplexer stages applies them in turn: the first stage moves the word by 1 position or not at all, the next by 2, then 4, 8 and 16. A 2-bit operation code shared by every stage picks one of four behaviours: pass the word through, logical left, logical right, or arithmetic right.

Vacated positions are filled with zeros for the two logical shifts. The arithmetic right shift fills them with copies of the word's sign bit, so a negative value stays negative. The combinational cascade feeds a single output register, so a result appears one clock after its operands are presented.

Top module: `bshift_top`

## Requirements
- R1: Operation code 2'b00 (pass) returns the operand unchanged for every shift distance.
- R2: A shift distance of 0 returns the operand unchanged for every operation code.
- R3: Operation code 2'b01 (logical left) returns the operand shifted toward bit 31 by the distance, with zeros entering at bit 0.
- R4: Operation code 2'b10 (logical right) returns the operand shifted toward bit 0 by the distance, with zeros entering at bit 31.
- R5: Operation code 2'b11 (arithmetic right) returns the operand shifted toward bit 0 by the distance, with every vacated position holding the operand's bit 31.
- R6: The result is registered: it shows the operands presented before the latest rising clock edge, and an active-low reset clears it to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset, clears the result |
| opnd | input | 32 | Word to be shifted |
| fn | input | 2 | Operation: 00 pass, 01 logical left, 10 logical right, 11 arithmetic right |
| amt | input | 5 | Shift distance, 0 to 31 |
| result | output | 32 | Registered shifted word |

## Verification
The assertions watch every cycle for the properties that need no reference model: pass-through on code 00 or a zero distance, a zero entering the far end on logical shifts, and the sign bit surviving an arithmetic right shift. Whether every bit lands in the right place for each distance and code, and the reset value, can only be shown by the bench's scenarios, which sweep all 128 code and distance pairs over several operands and compare against the language's own shift operators.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        FN_PASS = 2'b00,
        FN_SLL  = 2'b01,
        FN_SRL  = 2'b10,
        FN_SRA  = 2'b11
    } shift_fn_e;

endpackage

// File: rtl/bshift_stage.sv
module bshift_stage
    import bshift_pkg::*;
#(
    parameter int WIDTH = WORD_W,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0] din,
    input  shift_fn_e        fn,
    input  logic             en,
    output logic [WIDTH-1:0] dout
);

    always_comb begin
        if (!en) begin
            dout = din;
        end else begin
            unique case (fn)
                FN_PASS: dout = din;
                FN_SLL:  dout = {din[WIDTH-1-DIST:0], {DIST{1'b0}}};
                FN_SRL:  dout = {{DIST{1'b0}}, din[WIDTH-1:DIST]};
                FN_SRA:  dout = {{DIST{din[WIDTH-1]}}, din[WIDTH-1:DIST]};
                default: dout = din;
            endcase
        end
    end

endmodule

// File: rtl/bshift_cascade.sv
module bshift_cascade
    import bshift_pkg::*;
#(
    parameter int WIDTH = WORD_W,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  shift_fn_e        fn,
    input  logic [AMT_W-1:0] amt,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] tap [AMT_W+1];

    assign tap[0] = din;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        bshift_stage #(
            .WIDTH (WIDTH),
            .DIST  (1 << k)
        ) u_stage (
            .din  (tap[k]),
            .fn   (fn),
            .en   (amt[k]),
            .dout (tap[k+1])
        );
    end

    assign dout = tap[AMT_W];

endmodule

// File: rtl/bshift_top.sv
module bshift_top
    import bshift_pkg::*;
#(
    parameter int WIDTH = WORD_W,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opnd,
    input  logic [1:0]       fn,
    input  logic [AMT_W-1:0] amt,
    output logic [WIDTH-1:0] result
);

    typedef struct packed {
        logic [WIDTH-1:0] result;
    } state_t;

    state_t           state_d;
    state_t           state_q;
    logic [WIDTH-1:0] shifted;

    bshift_cascade #(
        .WIDTH (WIDTH)
    ) u_cascade (
        .din  (opnd),
        .fn   (shift_fn_e'(fn)),
        .amt  (amt),
        .dout (shifted)
    );

    always_comb begin
        state_d        = state_q;
        state_d.result = shifted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result = state_q.result;

endmodule

// File: rtl/bshift_checker.sv
module bshift_checker #(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] opnd,
    input logic [1:0]       fn,
    input logic [AMT_W-1:0] amt,
    input logic [WIDTH-1:0] result
);

    a_r1_pass_code: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == 2'b00) |=> (result == $past(opnd)));

    a_r2_zero_dist: assert property (@(posedge clk) disable iff (!rst_n)
        (amt == '0) |=> (result == $past(opnd)));

    a_r3_left_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == 2'b01 && amt != '0) |=> (result[0] == 1'b0));

    a_r4_right_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == 2'b10 && amt != '0) |=> (result[WIDTH-1] == 1'b0));

    a_r5_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == 2'b11) |=> (result[WIDTH-1] == $past(opnd[WIDTH-1])));

    a_r5_sign_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == 2'b11 && amt != '0) |=> (result[WIDTH-1] == result[WIDTH-2]));

endmodule

bind bshift_top bshift_checker #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .opnd   (opnd),
    .fn     (fn),
    .amt    (amt),
    .result (result)
);

// File: tb/bshift_top_bench.sv
module bshift_top_bench;

    localparam int W     = 32;
    localparam int AW    = 5;
    localparam int LIMIT = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  opnd = '0;
    logic [1:0]    fn = 2'b00;
    logic [AW-1:0] amt = '0;
    logic [W-1:0]  result;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
        logic [1:0]   fn;
        int           amt;
    } item_t;

    item_t sb_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    bit    armed = 1'b0;

    bshift_top u_bshift_top (
        .clk    (clk),
        .rst_n  (rst_n),
        .opnd   (opnd),
        .fn     (fn),
        .amt    (amt),
        .result (result)
    );

    always #10 clk = ~clk;

    function automatic logic [W-1:0] model(logic [W-1:0] v, logic [1:0] f, int a);
        case (f)
            2'b00:   return v;
            2'b01:   return v << a;
            2'b10:   return v >> a;
            default: return W'($signed(v) >>> a);
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] f, int a);
        if (f == 2'b00) return "R1";
        if (a == 0)     return "R2";
        if (f == 2'b01) return "R3";
        if (f == 2'b10) return "R4";
        return "R5";
    endfunction

    task automatic drive(logic [W-1:0] v, logic [1:0] f, int a);
        item_t it;
        @(negedge clk);
        opnd = v;
        fn   = f;
        amt  = AW'(a);
        it.exp = model(v, f, a);
        it.tag = tag_of(f, a);
        it.fn  = f;
        it.amt = a;
        sb_q.push_back(it);
    endtask

    // monitor: one registered result per rising edge
    always @(posedge clk) begin
        #1;
        if (armed && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (result !== it.exp) begin
                n_bad++;
                $display("FAIL %s fn=%b amt=%0d: got %h expected %h",
                         it.tag, it.fn, it.amt, result, it.exp);
            end
        end
    end

    initial begin
        logic [W-1:0] ops [6];
        ops[0] = 32'h8000_0001;
        ops[1] = 32'hDEAD_BEEF;
        ops[2] = 32'h7FFF_FFFE;
        ops[3] = 32'h0F0F_5AA5;
        ops[4] = 32'hFFFF_FFFF;
        ops[5] = 32'h0000_0001;

        // R6: reset value
        repeat (3) @(negedge clk);
        n_cmp++;
        if (result !== '0) begin
            n_bad++;
            $display("FAIL R6 reset: got %h expected %h", result, 32'h0);
        end
        opnd = 32'h1234_5678;
        @(negedge clk);
        rst_n = 1'b1;
        armed = 1'b1;

        for (int o = 0; o < 6; o++) begin
            for (int f = 0; f < 4; f++) begin
                for (int a = 0; a < W; a++) begin
                    drive(ops[o], 2'(f), a);
                end
            end
        end

        // R6: result follows one edge later, back-to-back changes
        drive(32'hA5A5_0000, 2'b10, 4);
        drive(32'h0000_A5A5, 2'b01, 4);
        drive(32'h8000_0000, 2'b11, 31);

        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < LIMIT; c++) begin
            @(posedge clk);
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule